// File: doc/BRIEF.md
# In-Order Data Tenure Sequencer

This block sits on the bus side of a shared cache that serves up to four processors. Every processor has its own request line, its own address grant and its own data grant. The sequencer hands out address tenures one at a time. It records each acknowledged tenure in a short queue of processor numbers. It then grants the data bus strictly in that recorded order, across all processors, and never lets more than one transaction wait behind the one that is moving data.

An address tenure that is retried in the cycle after its acknowledge is aborted. It leaves the queue without ever getting the data bus. When nothing is queued and the data bus is quiet, the sequencer can park the data grant on the processor that last finished a data tenure. It must not park when fast mode is on and more than one processor is installed, because a retry can then abort a read hit that would otherwise be served from the parked bus. The data path itself is outside this block.

Top module: `dtenure_seq_top`

## Requirements
- R1: `abg_o` is one-hot or zero. An address grant is a one-cycle pulse. It appears in the cycle after the sequencer, idle, samples a request. No further address grant is given until the granted tenure has been acknowledged and its retry cycle has passed. Bit i of every per-processor vector belongs to processor i.
- R2: When several processors request in the same cycle, the winner is the first requester found searching upward, with wrap-around, from the processor just above the one granted last. After reset the search starts at processor 0.
- R3: While two acknowledged tenures are queued, no address grant is given, even with requests pending.
- R4: Data grants go out in the order in which address tenures were acknowledged, whatever the processor numbers are.
- R5: A retry (`artry_i` high in the cycle right after the one in which `aack_i` was taken) aborts that tenure. It never receives a data grant, and tenures queued ahead of it are unaffected. This holds both when the aborted tenure is alone in the queue and when it sits behind another.
- R6: A data grant is a one-cycle pulse to the processor at the head of the queue. It appears in the cycle after the head's retry cycle has passed and the data bus is free. While a data tenure is in progress, no other data grant is issued.
- R7: `dcomp_i` high during a data tenure ends it and removes its entry from the queue. The next data grant can follow one cycle later.
- R8: Once at least one data tenure has completed, and while parking is allowed, the queue is empty and no data tenure is in progress, `dbg_o` is held high for the processor whose data tenure completed last.
- R9: Parking is suppressed while `fast_mode_i` is high and more than one bit of `cpu_present_i` is set. With fast mode on and a single processor present, parking is allowed.
- R10: During and right after reset, `abg_o` and `dbg_o` are zero. Nothing is parked before the first data tenure completes.
- R11: `aack_i` while no address tenure is awaiting acknowledge, `artry_i` outside the retry cycle, and `dcomp_i` while no data tenure is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| breq_i | input | NUM_PROC | Per-processor bus request, held until granted |
| aack_i | input | 1 | Address tenure acknowledge |
| artry_i | input | 1 | Address retry, sampled in the cycle after acknowledge |
| dcomp_i | input | 1 | Current data tenure complete |
| fast_mode_i | input | 1 | Fast mode flag |
| cpu_present_i | input | NUM_PROC | Which processors are installed |
| abg_o | output | NUM_PROC | Per-processor address grant pulse |
| dbg_o | output | NUM_PROC | Per-processor data grant (pulse, or level when parked) |

## Verification
The bench drives interleaved tenures from several processors whose numbers run against their grant order. A sequencer that granted the data bus by processor number, or in rotation, would send the data grant to the wrong processor there. It retries a tenure that sits behind a busy one and also one that is alone in the queue. A design that popped the wrong slot, or that let a tentative entry through, would grant an aborted transaction or starve the one ahead of it. It fills the two-entry queue and holds a request against it, so an overflowing design would hand out a third address grant. It walks the parking rule through fast mode with four processors and with one, where a wrong count of installed processors would park when it should not, or the reverse. It also sends stray acknowledge and completion pulses, which a careless design would turn into phantom queue entries.

// File: rtl/dts_pkg.sv
package dts_pkg;

  // Phase of the single outstanding address tenure.
  typedef enum logic [1:0] {
    AP_IDLE = 2'd0,   // free to grant
    AP_WAIT = 2'd1,   // granted, waiting for acknowledge
    AP_RTY  = 2'd2    // acknowledged, retry may arrive this cycle
  } addr_phase_e;

endpackage

// File: rtl/dts_rst_sync.sv
module dts_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/dts_rr_arb.sv
module dts_rr_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] win_id_o,
  output logic [N-1:0]  win_oh_o
);

  logic [IW-1:0] ptr_q, ptr_n;
  logic [IW-1:0] win_id;
  logic          any;

  // search upward from the slot just above the last winner
  always_comb begin
    int unsigned idx;
    win_id = '0;
    any    = 1'b0;
    idx    = 0;
    for (int unsigned off = 1; off <= N; off++) begin
      idx = (int'(ptr_q) + off) % N;
      if (!any && req_i[idx]) begin
        any    = 1'b1;
        win_id = IW'(idx);
      end
    end
  end

  always_comb begin
    win_oh_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      win_oh_o[i] = any && (win_id == IW'(i));
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (adv_i && any) begin
      ptr_n = win_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IW'(N - 1);
    end else if (adv_i) begin
      ptr_q <= ptr_n;
    end
  end

  assign any_o    = any;
  assign win_id_o = win_id;

  // R2: an accepted winner is always a live requester
  p_win_is_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> req_i[win_id]);

endmodule

// File: rtl/dts_order_q.sv
module dts_order_q #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IW    = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [IW-1:0] push_id_i,
  input  logic          confirm_i,
  input  logic          kill_i,
  input  logic          pop_i,
  output logic          head_rdy_o,
  output logic [IW-1:0] head_id_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [IW-1:0] id_q   [DEPTH];
  logic [IW-1:0] id_n   [DEPTH];
  logic [DEPTH-1:0] tent_q, tent_n;
  logic [CW-1:0] occ_q, occ_n;
  logic          q_en;
  logic          tail_tent;

  assign q_en = push_i | pop_i | confirm_i | kill_i;

  // next state: retire retry window, then pop head, then append
  always_comb begin
    id_n   = id_q;
    tent_n = tent_q;
    occ_n  = occ_q;
    if (kill_i && occ_n != '0) begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
        if (CW'(i) == occ_n - 1'b1) tent_n[i] = 1'b0;
      end
      occ_n = occ_n - 1'b1;
    end
    if (confirm_i && occ_n != '0) begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
        if (CW'(i) == occ_n - 1'b1) tent_n[i] = 1'b0;
      end
    end
    if (pop_i && occ_n != '0) begin
      for (int unsigned i = 0; i + 1 < DEPTH; i++) begin
        id_n[i]   = id_n[i+1];
        tent_n[i] = tent_n[i+1];
      end
      id_n[DEPTH-1]   = '0;
      tent_n[DEPTH-1] = 1'b0;
      occ_n = occ_n - 1'b1;
    end
    if (push_i && occ_n < CW'(DEPTH)) begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
        if (CW'(i) == occ_n) begin
          id_n[i]   = push_id_i;
          tent_n[i] = 1'b1;
        end
      end
      occ_n = occ_n + 1'b1;
    end
  end

  always_comb begin
    tail_tent = 1'b0;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      if (CW'(i) + 1'b1 == occ_q) tail_tent = tent_q[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          id_q[g]   <= '0;
          tent_q[g] <= 1'b0;
        end else if (q_en) begin
          id_q[g]   <= id_n[g];
          tent_q[g] <= tent_n[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (q_en) begin
      occ_q <= occ_n;
    end
  end

  assign head_rdy_o = (occ_q != '0) && !tent_q[0];
  assign head_id_o  = id_q[0];
  assign full_o     = (occ_q == CW'(DEPTH));
  assign empty_o    = (occ_q == '0);

  // R3: the address side never appends to a full queue
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (occ_q < CW'(DEPTH)));

  // R5: a retry always lands on a still-tentative tail entry
  p_kill_tentative_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i || confirm_i) |-> (occ_q != '0 && tail_tent));

  // R7: completion only ever retires an existing entry
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (occ_q != '0));

endmodule

// File: rtl/dts_dgrant.sv
module dts_dgrant #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_rdy_i,
  input  logic [IW-1:0] head_id_i,
  input  logic          q_empty_i,
  input  logic          dcomp_i,
  input  logic          fast_i,
  input  logic [N-1:0]  present_i,
  output logic          pop_o,
  output logic [N-1:0]  dbg_o
);

  logic          dbusy_q, dbusy_n;
  logic          park_vld_q, park_vld_n;
  logic [IW-1:0] park_id_q, park_id_n;
  logic [N-1:0]  dbg_q, dbg_n;
  logic          fire;
  logic          pop;
  logic          multi;
  logic          park_on;

  always_comb begin
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < N; i++) begin
      cnt = cnt + {31'd0, present_i[i]};
    end
    multi = (cnt > 1);
  end

  assign fire    = head_rdy_i && !dbusy_q;
  assign pop     = dbusy_q && dcomp_i;
  assign park_on = park_vld_q && !(fast_i && multi) && !dbusy_q && q_empty_i;

  always_comb begin
    dbusy_n    = dbusy_q;
    park_vld_n = park_vld_q;
    park_id_n  = park_id_q;
    if (fire) begin
      dbusy_n = 1'b1;
    end else if (pop) begin
      dbusy_n    = 1'b0;
      park_vld_n = 1'b1;
      park_id_n  = head_id_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      assign dbg_n[g] = (fire && head_id_i == IW'(g)) ||
                        (park_on && park_id_q == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbusy_q    <= 1'b0;
      park_vld_q <= 1'b0;
      park_id_q  <= '0;
      dbg_q      <= '0;
    end else begin
      dbg_q <= dbg_n;
      if (fire || pop) begin
        dbusy_q    <= dbusy_n;
        park_vld_q <= park_vld_n;
        park_id_q  <= park_id_n;
      end
    end
  end

  assign pop_o = pop;
  assign dbg_o = dbg_q;

  // R4: at most one processor holds the data bus
  p_dgrant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbg_o));

  // R9: with fast mode and several processors, grants never stay on
  p_no_park_fast_mp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_i && multi && |dbg_o) |=> !(|dbg_o));

  // R6: no new grant while a tenure is moving data
  p_single_tenure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbusy_q && !dcomp_i && !(|dbg_o)) |=> !(|dbg_o));

endmodule

// File: rtl/dtenure_seq_top.sv
module dtenure_seq_top
  import dts_pkg::*;
#(
  parameter int unsigned NUM_PROC = 4,
  parameter int unsigned Q_DEPTH  = 2,
  localparam int unsigned IW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROC-1:0] breq_i,
  input  logic                aack_i,
  input  logic                artry_i,
  input  logic                dcomp_i,
  input  logic                fast_mode_i,
  input  logic [NUM_PROC-1:0] cpu_present_i,
  output logic [NUM_PROC-1:0] abg_o,
  output logic [NUM_PROC-1:0] dbg_o
);

  logic          rst_ns;
  addr_phase_e   ph_q, ph_n;
  logic [IW-1:0] owner_q, owner_n;
  logic [NUM_PROC-1:0] abg_q, abg_n;

  logic          arb_any;
  logic [IW-1:0] arb_id;
  logic [NUM_PROC-1:0] arb_oh;
  logic          arb_adv;

  logic q_push, q_confirm, q_kill, q_pop;
  logic q_head_rdy, q_full, q_empty;
  logic [IW-1:0] q_head_id;

  dts_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  dts_rr_arb #(.N(NUM_PROC), .IW(IW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_ns),
    .req_i    (breq_i),
    .adv_i    (arb_adv),
    .any_o    (arb_any),
    .win_id_o (arb_id),
    .win_oh_o (arb_oh)
  );

  // address-tenure phase control
  always_comb begin
    ph_n      = ph_q;
    owner_n   = owner_q;
    abg_n     = '0;
    arb_adv   = 1'b0;
    q_push    = 1'b0;
    q_confirm = 1'b0;
    q_kill    = 1'b0;
    unique case (ph_q)
      AP_IDLE: begin
        if (arb_any && !q_full) begin
          arb_adv = 1'b1;
          abg_n   = arb_oh;
          owner_n = arb_id;
          ph_n    = AP_WAIT;
        end
      end
      AP_WAIT: begin
        if (aack_i) begin
          q_push = 1'b1;
          ph_n   = AP_RTY;
        end
      end
      AP_RTY: begin
        q_kill    = artry_i;
        q_confirm = !artry_i;
        ph_n      = AP_IDLE;
      end
      default: ph_n = AP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ph_q    <= AP_IDLE;
      owner_q <= '0;
      abg_q   <= '0;
    end else begin
      ph_q  <= ph_n;
      abg_q <= abg_n;
      if (arb_adv) begin
        owner_q <= owner_n;
      end
    end
  end

  dts_order_q #(.DEPTH(Q_DEPTH), .IW(IW)) u_q (
    .clk        (clk),
    .rst_n      (rst_ns),
    .push_i     (q_push),
    .push_id_i  (owner_q),
    .confirm_i  (q_confirm),
    .kill_i     (q_kill),
    .pop_i      (q_pop),
    .head_rdy_o (q_head_rdy),
    .head_id_o  (q_head_id),
    .full_o     (q_full),
    .empty_o    (q_empty)
  );

  dts_dgrant #(.N(NUM_PROC), .IW(IW)) u_dg (
    .clk        (clk),
    .rst_n      (rst_ns),
    .head_rdy_i (q_head_rdy),
    .head_id_i  (q_head_id),
    .q_empty_i  (q_empty),
    .dcomp_i    (dcomp_i),
    .fast_i     (fast_mode_i),
    .present_i  (cpu_present_i),
    .pop_o      (q_pop),
    .dbg_o      (dbg_o)
  );

  assign abg_o = abg_q;

  // R1: address grant is one-hot
  p_abg_onehot_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(abg_o));

  // R1: address grant lasts a single cycle
  p_abg_pulse_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (|abg_o) |=> !(|abg_o));

  // R3: a full queue holds off the next address grant
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (ph_q == AP_IDLE && q_full) |=> !(|abg_o));

  // R11: acknowledge outside the wait phase changes nothing
  p_stray_aack_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (ph_q == AP_IDLE && !arb_any) |=> (ph_q == AP_IDLE));

endmodule

// File: tb/dtenure_seq_top_tb_top.sv
`timescale 1ns/1ps
module dtenure_seq_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] breq;
  logic       aack, artry, dcomp, fast;
  logic [3:0] present;
  logic [3:0] abg, dbg;

  int n_chk;
  int n_bad;
  bit done;

  dtenure_seq_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .breq_i        (breq),
    .aack_i        (aack),
    .artry_i       (artry),
    .dcomp_i       (dcomp),
    .fast_mode_i   (fast),
    .cpu_present_i (present),
    .abg_o         (abg),
    .dbg_o         (dbg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // row: {request, aack, artry, dcomp, expected abg, expected dbg}
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {4'b0011, 3'b000, 4'b0001, 4'b0000},  // R2 first search from 0
    {4'b0010, 3'b100, 4'b0000, 4'b0000},
    {4'b0010, 3'b000, 4'b0000, 4'b0000},
    {4'b0010, 3'b000, 4'b0010, 4'b0001},  // R2 rotate, R6 head grant
    {4'b0000, 3'b100, 4'b0000, 4'b0000},
    {4'b0000, 3'b000, 4'b0000, 4'b0000},
    {4'b0100, 3'b000, 4'b0000, 4'b0000},  // R3 full
    {4'b0100, 3'b001, 4'b0000, 4'b0000},  // R3 still full, R7 pop
    {4'b0100, 3'b000, 4'b0100, 4'b0010},  // R4 order
    {4'b0000, 3'b100, 4'b0000, 4'b0000},
    {4'b0000, 3'b010, 4'b0000, 4'b0000},  // R5 retry behind busy
    {4'b0000, 3'b001, 4'b0000, 4'b0000},
    {4'b0000, 3'b000, 4'b0000, 4'b0000},  // R5 no grant for aborted
    {4'b1001, 3'b000, 4'b1000, 4'b0000},  // R2 wrap
    {4'b0001, 3'b100, 4'b0000, 4'b0000},
    {4'b0001, 3'b000, 4'b0000, 4'b0000},
    {4'b0001, 3'b000, 4'b0001, 4'b1000},  // R4 higher id first
    {4'b0000, 3'b100, 4'b0000, 4'b0000},
    {4'b0000, 3'b010, 4'b0000, 4'b0000},
    {4'b0000, 3'b001, 4'b0000, 4'b0000},
    {4'b0000, 3'b000, 4'b0000, 4'b0000}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    breq = '0; aack = 0; artry = 0; dcomp = 0;
    fast = 1'b1; present = 4'b1111;

    // R10 reset state
    tick(); tick();
    chk("R10 abg in reset", abg, 4'b0000);
    chk("R10 dbg in reset", dbg, 4'b0000);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk("R10 abg after reset", abg, 4'b0000);
    chk("R10 dbg after reset", dbg, 4'b0000);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      breq  = VEC[i][14:11];
      aack  = VEC[i][10];
      artry = VEC[i][9];
      dcomp = VEC[i][8];
      tick();
      chk($sformatf("R1/R2/R3 row %0d abg", i), abg, VEC[i][7:4]);
      chk($sformatf("R4/R5/R6/R7 row %0d dbg", i), dbg, VEC[i][3:0]);
    end
    breq = '0; aack = 0; artry = 0; dcomp = 0;

    // R8 parking on the last completed owner (processor 3)
    fast = 1'b0;
    tick();
    chk("R8 parked on last owner", dbg, 4'b1000);
    tick();
    chk("R8 park held", dbg, 4'b1000);

    // R9 fast mode, several processors: no parking
    fast = 1'b1;
    tick();
    chk("R9 fast multi no park", dbg, 4'b0000);
    present = 4'b0100;
    tick();
    chk("R9 fast single park", dbg, 4'b1000);
    present = 4'b1111;
    tick();
    chk("R9 back to multi", dbg, 4'b0000);

    // R11 stray acknowledge, retry and completion
    aack = 1; artry = 1; dcomp = 1;
    tick();
    chk("R11 stray abg", abg, 4'b0000);
    aack = 0; artry = 0; dcomp = 0;
    tick();
    chk("R11 no phantom dbg a", dbg, 4'b0000);
    tick();
    chk("R11 no phantom dbg b", dbg, 4'b0000);

    // R5 retry of a lone tentative entry
    breq = 4'b0100;
    tick();
    chk("R5 lone grant", abg, 4'b0100);
    breq = 0; aack = 1;
    tick();
    aack = 0; artry = 1;
    tick();
    artry = 0;
    tick();
    chk("R5 aborted lone a", dbg, 4'b0000);
    tick();
    chk("R5 aborted lone b", dbg, 4'b0000);

    // R6 wait for completion before the next data grant
    breq = 4'b0010;
    tick();
    chk("R2 grant after rotate", abg, 4'b0010);
    breq = 0; aack = 1;
    tick();
    aack = 0;
    tick();
    tick();
    chk("R6 head grant pulse", dbg, 4'b0010);
    breq = 4'b1000;
    tick();
    chk("R6 pulse ends", dbg, 4'b0000);
    chk("R2 second grant", abg, 4'b1000);
    breq = 0; aack = 1;
    tick();
    aack = 0;
    tick();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 held while busy", dbg, 4'b0000);
    end
    dcomp = 1;
    tick();
    chk("R7 pop cycle", dbg, 4'b0000);
    dcomp = 0;
    tick();
    chk("R4 next in order", dbg, 4'b1000);
    dcomp = 1;
    tick();
    dcomp = 0;
    tick();
    chk("R9 idle fast multi", dbg, 4'b0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule